// File: doc/BRIEF.md
# Load Return Alignment Control Decoder

This block turns the attributes of a load into the control word for a 64-bit load-return alignment datapath. The load attributes are access size, the low three address bits, byte order and signedness. The datapath itself sits outside the block. In it, each of the eight result lanes picks one source byte from the raw doubleword through a one-hot select. Each lane above lane 0 then either passes that byte, forces it to all ones, or reads zero. The block also takes the raw doubleword, because it needs the sign bit of whichever source byte becomes the most significant byte of the access.

Lanes 0 and 1 can reach every source byte. The other six lanes have only four-way selects, each wired to a fixed set of four source bytes. The decoder must therefore only ever request a source that the lane is wired to. Lanes above the access size are left pointing at their own source byte, so their selects stay one-hot. Low address bits that fall below the access size are treated as zero; misaligned accesses are trapped elsewhere.

A parameter chooses between two forms. One is a purely combinational decoder. The other registers the control word on each valid request and holds it between requests, so that the word lines up with the data-return stage one cycle later.

Top module: `ldalign_ctl_dec`

## Requirements
- R1: While `o_vld` is high, the 8-bit select of lane 0 (`o_wide_sel[7:0]`) and the 8-bit select of lane 1 (`o_wide_sel[15:8]`) each have exactly one bit set. Bit b picks source byte b, where source byte b is `i_data[8b+7:8b]`.
- R2: While `o_vld` is high, each 4-bit select of lanes 2 to 7 has exactly one bit set. Lane k's select sits at `o_narrow_sel[4(k-2)+3:4(k-2)]`. For lanes 2, 5 and 6, bits 0 to 3 pick source bytes 1, 2, 5 and 6. For lanes 3, 4 and 7, bits 0 to 3 pick source bytes 0, 3, 4 and 7.
- R3: The byte at address offset a is source byte 7-a. The size code is 0 for byte, 1 for halfword, 2 for word and 3 for doubleword, and the access covers N = 2^size bytes. With `i_little` low (big-endian), result lane k < N takes the byte at offset base+N-1-k, so the addressed byte lands in the most significant lane of the access.
- R4: With `i_little` high, result lane k < N takes the byte at offset base+k, which reverses the order of the bytes within the access.
- R5: `o_pass[k]` is high exactly for the lanes 1 ≤ k < N.
- R6: For the lanes k ≥ N, `o_ones[k]` is high only when `i_signed` is high and bit 7 of the access's most significant byte is 1; otherwise those lanes read zero. `o_pass` and `o_ones` are never both high on the same lane.
- R7: A doubleword access passes all lanes and asserts no ones-fill. For narrower accesses, every lane k ≥ N selects source byte k.
- R8: Address bits below the access size are ignored: base = address with its low size bits cleared.
- R9: With PIPE=1, the control word appears one clock after it is sampled with `i_vld` high, and is held while `i_vld` is low. `o_vld` is `i_vld` delayed by one clock. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_vld | input | 1 | Load request valid |
| i_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 double) |
| i_addr | input | 3 | Byte offset within the doubleword |
| i_little | input | 1 | Little-endian access |
| i_signed | input | 1 | Signed load |
| i_data | input | 64 | Raw doubleword, used for the sign bit |
| o_vld | output | 1 | Control word valid |
| o_wide_sel | output | 16 | One-hot selects for lanes 0 and 1 |
| o_narrow_sel | output | 24 | One-hot selects for lanes 2 to 7 |
| o_pass | output | 7 | Pass-data controls for lanes 1 to 7 |
| o_ones | output | 7 | Ones-fill controls for lanes 1 to 7 |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, eight lanes and PIPE=1. This makes the complete request space small enough to sweep in full: every size, every offset including the misaligned ones, both byte orders and both signedness settings. Each request is run against data patterns whose byte sign bits are all clear, all set, or alternate. The control word goes through a model of the restricted multiplexers and is compared with an arithmetic load-format function, covering both the integer result and the unextended floating-point bytes. The registered form also puts the hold-while-idle and reset behaviour within reach.

// File: rtl/ldalign_pkg.sv
package ldalign_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } ld_size_e;

   // Number of ways of a restricted lane select
   localparam int unsigned NARROW_WAYS = 4;
   // Lanes with a full any-byte select
   localparam int unsigned WIDE_LANES  = 2;

   // Lanes whose two low index bits differ belong to the {1,2,5,6} group;
   // the other lanes belong to the {0,3,4,7} group.
   function automatic logic lane_in_group_a(input int unsigned lane);
      return lane[1] ^ lane[0];
   endfunction

   function automatic logic src_in_group_a(input logic [2:0] src);
      return src[1] ^ src[0];
   endfunction

   // Position of a source byte within its group's four-way select
   function automatic logic [1:0] narrow_code(input logic [2:0] src);
      return {src[2], src[1]};
   endfunction

endpackage

// File: rtl/ldalign_lane_map.sv
module ldalign_lane_map
   import ldalign_pkg::*;
#(
   parameter int unsigned LANES = 8,
   localparam int unsigned SRC_W = $clog2(LANES)
) (
   input  logic [1:0]                  size,
   input  logic [SRC_W-1:0]            addr,
   input  logic                        little,
   output logic [LANES-1:0][SRC_W-1:0] src_idx,
   output logic [SRC_W-1:0]            top_src
);

   localparam int unsigned CNT_W = SRC_W + 1;

   logic [CNT_W-1:0] nbytes;
   logic [SRC_W-1:0] low_mask;
   logic [SRC_W-1:0] base;
   logic [SRC_W-1:0] top_off;

   always_comb begin
      nbytes   = CNT_W'(1) << size;
      low_mask = SRC_W'(nbytes - CNT_W'(1));
      base     = addr & ~low_mask;
      top_off  = little ? (base + low_mask) : base;
      top_src  = SRC_W'(LANES - 1) - top_off;
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [SRC_W-1:0] off;
      always_comb begin
         if (CNT_W'(k) < nbytes) begin
            if (little) off = base + SRC_W'(k);
            else        off = base + low_mask - SRC_W'(k);
            src_idx[k] = SRC_W'(LANES - 1) - off;
         end else begin
            off        = '0;
            src_idx[k] = SRC_W'(k);
         end
      end
   end

endmodule

// File: rtl/ldalign_sel_enc.sv
module ldalign_sel_enc
   import ldalign_pkg::*;
#(
   parameter int unsigned LANES = 8,
   localparam int unsigned SRC_W    = $clog2(LANES),
   localparam int unsigned WIDE_W   = WIDE_LANES * LANES,
   localparam int unsigned NARROW_W = (LANES - WIDE_LANES) * NARROW_WAYS
) (
   input  logic [LANES-1:0][SRC_W-1:0] src_idx,
   output logic [WIDE_W-1:0]           wide_sel,
   output logic [NARROW_W-1:0]         narrow_sel
);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      if (k < WIDE_LANES) begin : g_wide
         always_comb begin
            wide_sel[k*LANES +: LANES] = '0;
            wide_sel[k*LANES + int'(src_idx[k])] = 1'b1;
         end
      end else begin : g_narrow
         localparam logic GRP_A = lane_in_group_a(k);
         logic wired;
         always_comb begin
            wired = (src_in_group_a(src_idx[k]) == GRP_A);
            narrow_sel[(k-WIDE_LANES)*NARROW_WAYS +: NARROW_WAYS] = '0;
            if (wired)
               narrow_sel[(k-WIDE_LANES)*NARROW_WAYS + int'(narrow_code(src_idx[k]))] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/ldalign_ext_ctl.sv
module ldalign_ext_ctl #(
   parameter int unsigned LANES  = 8,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned SRC_W = $clog2(LANES)
) (
   input  logic [1:0]              size,
   input  logic                    sgn,
   input  logic [LANES*BYTE_W-1:0] data,
   input  logic [SRC_W-1:0]        top_src,
   output logic [LANES-1:1]        pass,
   output logic [LANES-1:1]        ones
);

   localparam int unsigned CNT_W = SRC_W + 1;

   logic [LANES-1:0][BYTE_W-1:0] bytes;
   logic [CNT_W-1:0]             nbytes;
   logic                         fill;

   always_comb begin
      bytes  = data;
      nbytes = CNT_W'(1) << size;
      fill   = sgn & bytes[top_src][BYTE_W-1];
   end

   for (genvar k = 1; k < LANES; k++) begin : g_lane
      always_comb begin
         pass[k] = CNT_W'(k) < nbytes;
         ones[k] = ~pass[k] & fill;
      end
   end

endmodule

// File: rtl/ldalign_ctl_dec.sv
module ldalign_ctl_dec
   import ldalign_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned LANES  = 8,
   parameter bit          PIPE   = 1'b1,
   localparam int unsigned SRC_W    = $clog2(LANES),
   localparam int unsigned DATA_W   = LANES * BYTE_W,
   localparam int unsigned WIDE_W   = WIDE_LANES * LANES,
   localparam int unsigned NARROW_W = (LANES - WIDE_LANES) * NARROW_WAYS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                i_vld,
   input  logic [1:0]          i_size,
   input  logic [SRC_W-1:0]    i_addr,
   input  logic                i_little,
   input  logic                i_signed,
   input  logic [DATA_W-1:0]   i_data,
   output logic                o_vld,
   output logic [WIDE_W-1:0]   o_wide_sel,
   output logic [NARROW_W-1:0] o_narrow_sel,
   output logic [LANES-1:1]    o_pass,
   output logic [LANES-1:1]    o_ones
);

   if (LANES != 8) begin : g_bad_lanes
      $error("ldalign_ctl_dec: restricted lane wiring needs LANES == 8");
   end
   if (BYTE_W < 2) begin : g_bad_byte
      $error("ldalign_ctl_dec: BYTE_W must be at least 2");
   end

   logic [LANES-1:0][SRC_W-1:0] src_idx;
   logic [SRC_W-1:0]            top_src;
   logic [WIDE_W-1:0]           wide_d;
   logic [NARROW_W-1:0]         narrow_d;
   logic [LANES-1:1]            pass_d;
   logic [LANES-1:1]            ones_d;

   ldalign_lane_map #(.LANES(LANES)) u_map (
      .size    (i_size),
      .addr    (i_addr),
      .little  (i_little),
      .src_idx (src_idx),
      .top_src (top_src)
   );

   ldalign_sel_enc #(.LANES(LANES)) u_enc (
      .src_idx    (src_idx),
      .wide_sel   (wide_d),
      .narrow_sel (narrow_d)
   );

   ldalign_ext_ctl #(.LANES(LANES), .BYTE_W(BYTE_W)) u_ext (
      .size    (i_size),
      .sgn     (i_signed),
      .data    (i_data),
      .top_src (top_src),
      .pass    (pass_d),
      .ones    (ones_d)
   );

   if (PIPE) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            o_vld        <= 1'b0;
            o_wide_sel   <= '0;
            o_narrow_sel <= '0;
            o_pass       <= '0;
            o_ones       <= '0;
         end else begin
            o_vld <= i_vld;
            if (i_vld) begin
               o_wide_sel   <= wide_d;
               o_narrow_sel <= narrow_d;
               o_pass       <= pass_d;
               o_ones       <= ones_d;
            end
         end
      end

      AST_VLD_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
         i_vld |=> o_vld); // R9
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !i_vld |=> ($stable(o_pass) && $stable(o_ones) && $stable(o_wide_sel)
                     && $stable(o_narrow_sel))); // R9
   end else begin : g_comb
      always_comb begin
         o_vld        = i_vld;
         o_wide_sel   = wide_d;
         o_narrow_sel = narrow_d;
         o_pass       = pass_d;
         o_ones       = ones_d;
      end
   end

   for (genvar w = 0; w < WIDE_LANES; w++) begin : g_chk_wide
      AST_WIDE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
         o_vld |-> $countones(o_wide_sel[w*LANES +: LANES]) == 1); // R1
   end

   for (genvar n = 0; n < LANES - WIDE_LANES; n++) begin : g_chk_narrow
      AST_NARROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
         o_vld |-> $countones(o_narrow_sel[n*NARROW_WAYS +: NARROW_WAYS]) == 1); // R2
   end

   AST_PASS_ONES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      o_vld |-> (o_pass & o_ones) == '0); // R6
   AST_PASS_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
      o_vld |-> (({o_pass, 1'b1} + 1'b1) & {o_pass, 1'b1}) == '0); // R5
   AST_DWORD_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (o_vld && o_pass[LANES-1]) |-> o_ones == '0); // R7

endmodule

// File: tb/ldalign_ctl_dec_tb_top.sv
`timescale 1ns/1ps
module ldalign_ctl_dec_tb_top;

   localparam int BW = 8;
   localparam int NL = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        i_vld = 1'b0;
   logic [1:0]  i_size = '0;
   logic [2:0]  i_addr = '0;
   logic        i_little = 1'b0;
   logic        i_signed = 1'b0;
   logic [63:0] i_data = '0;
   logic        o_vld;
   logic [15:0] o_wide_sel;
   logic [23:0] o_narrow_sel;
   logic [7:1]  o_pass;
   logic [7:1]  o_ones;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ldalign_ctl_dec #(.BYTE_W(BW), .LANES(NL), .PIPE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .i_vld(i_vld), .i_size(i_size), .i_addr(i_addr),
      .i_little(i_little), .i_signed(i_signed), .i_data(i_data), .o_vld(o_vld),
      .o_wide_sel(o_wide_sel), .o_narrow_sel(o_narrow_sel), .o_pass(o_pass),
      .o_ones(o_ones)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] make_data(input int pat);
      logic [63:0] d;
      for (int j = 0; j < 8; j++) begin
         case (pat)
            0:       d[j*8 +: 8] = 8'h10 + 8'(j);
            1:       d[j*8 +: 8] = 8'h80 | 8'(j * 8'h11);
            default: d[j*8 +: 8] = ((j % 2) ? 8'h80 : 8'h00) | (8'h30 + 8'(j));
         endcase
      end
      return d;
   endfunction

   // Source byte chosen by a lane's select, or -1 when not one-hot
   function automatic int lane_src(input int k, input logic [15:0] w, input logic [23:0] n);
      int s;
      int a_set[4];
      int b_set[4];
      logic [3:0] nb;
      a_set = '{1, 2, 5, 6};
      b_set = '{0, 3, 4, 7};
      s = -1;
      if (k < 2) begin
         if ($countones(w[k*8 +: 8]) == 1)
            for (int b = 0; b < 8; b++) if (w[k*8+b]) s = b;
      end else begin
         nb = n[(k-2)*4 +: 4];
         if ($countones(nb) == 1)
            for (int b = 0; b < 4; b++)
               if (nb[b]) s = (k == 2 || k == 5 || k == 6) ? a_set[b] : b_set[b];
      end
      return s;
   endfunction

   task automatic run_vec(input int sz, input int ad, input bit le, input bit sg, input int pat);
      int nb, base, off, src, top;
      logic [63:0] d, exp_int, exp_fp, act_int, act_fp, fpmask;
      logic [7:1] exp_pass;
      bit fill, sel_ok;
      string tag;
      d = make_data(pat);
      i_vld = 1'b1; i_size = 2'(sz); i_addr = 3'(ad); i_little = le; i_signed = sg; i_data = d;
      @(posedge clk);
      @(negedge clk);
      i_vld = 1'b0;
      // reference load format
      nb = 1 << sz;
      base = ad & ~(nb - 1);
      exp_int = '0;
      for (int k = 0; k < nb; k++) begin
         off = le ? base + k : base + nb - 1 - k;
         exp_int[k*8 +: 8] = d[(7-off)*8 +: 8];
      end
      fill = sg && exp_int[(nb-1)*8 + 7];
      for (int k = nb; k < 8; k++) exp_int[k*8 +: 8] = fill ? 8'hFF : 8'h00;
      fpmask = (nb == 8) ? '1 : ((64'd1 << (nb*8)) - 1);
      exp_fp = exp_int & fpmask;
      exp_pass = 7'(((1 << nb) - 1) >> 1);
      // apply controls through a model of the lane muxes
      act_int = '0; act_fp = '0; sel_ok = 1'b1;
      for (int k = 0; k < 8; k++) begin
         src = lane_src(k, o_wide_sel, o_narrow_sel);
         if (src < 0) sel_ok = 1'b0;
         else begin
            act_fp[k*8 +: 8] = d[src*8 +: 8];
            if (k == 0 || o_pass[k]) act_int[k*8 +: 8] = d[src*8 +: 8];
            else if (o_ones[k])      act_int[k*8 +: 8] = 8'hFF;
         end
         if (k >= nb && sz != 3)
            chk(src == k, "R7", "idle lane source", 64'(src), 64'(k));
      end
      if (ad % nb != 0) tag = "R8";
      else if (sg)      tag = "R6";
      else if (le)      tag = "R4";
      else              tag = "R3";
      chk(o_vld == 1'b1, "R9", "valid delay", 64'(o_vld), 64'd1);
      chk($countones(o_wide_sel[7:0]) == 1 && $countones(o_wide_sel[15:8]) == 1,
          "R1", "wide one-hot", 64'(o_wide_sel), 64'd0);
      chk(sel_ok, "R2", "narrow one-hot", 64'(o_narrow_sel), 64'd0);
      chk(o_pass == exp_pass, "R5", "pass vector", 64'(o_pass), 64'(exp_pass));
      chk((o_pass & o_ones) == '0, "R6", "pass/ones overlap", 64'(o_ones), 64'd0);
      chk(act_int == exp_int, tag, "integer result", act_int, exp_int);
      chk((act_fp & fpmask) == exp_fp, le ? "R4" : "R3", "fp aligned bytes",
          act_fp & fpmask, exp_fp);
      if (sz == 3) chk(o_ones == '0, "R7", "dword fill", 64'(o_ones), 64'd0);
      top = 0;
   endtask

   initial begin
      logic [15:0] w_keep;
      logic [23:0] n_keep;
      logic [7:1]  p_keep, o_keep;
      repeat (3) @(negedge clk);
      chk(o_vld == 1'b0 && o_pass == '0 && o_ones == '0, "R9", "reset pass/ones/vld",
          {o_vld, o_pass, o_ones}, 64'd0);
      chk(o_wide_sel == '0 && o_narrow_sel == '0, "R9", "reset selects",
          {o_wide_sel, o_narrow_sel}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int sz = 0; sz < 4; sz++)
         for (int ad = 0; ad < 8; ad++)
            for (int le = 0; le < 2; le++)
               for (int sg = 0; sg < 2; sg++)
                  for (int pat = 0; pat < 3; pat++)
                     run_vec(sz, ad, le[0], sg[0], pat);
      // hold while idle: signed byte load with fill, then change inputs without valid
      run_vec(0, 5, 1'b0, 1'b1, 1);
      w_keep = o_wide_sel; n_keep = o_narrow_sel; p_keep = o_pass; o_keep = o_ones;
      i_vld = 1'b0; i_size = 2'd3; i_addr = 3'd0; i_little = 1'b1; i_signed = 1'b0;
      i_data = '0;
      @(posedge clk);
      @(negedge clk);
      chk(o_vld == 1'b0, "R9", "idle valid", 64'(o_vld), 64'd0);
      chk(o_wide_sel == w_keep && o_narrow_sel == n_keep, "R9", "idle select hold",
          {o_wide_sel, o_narrow_sel}, {w_keep, n_keep});
      chk(o_pass == p_keep && o_ones == o_keep, "R9", "idle ext hold",
          {o_pass, o_ones}, {p_keep, o_keep});
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule